// File: doc/BRIEF.md
# T1-to-E1 Slot Mapper

This block carries the payload of a channelized T1 line into an E1-format frame. It samples the T1 bit stream on a bit strobe from the 1.544 MHz line clock. A one-strobe frame pulse marks the framing bit. The block gathers the 24 eight-bit timeslots, most significant bit first, and drops the framing bit. It then sends them out again, most significant bit first, in a 32-slot E1 frame paced by a 2.048 MHz bit strobe. T1 slot n goes into E1 slot n. Every E1 slot that carries no T1 payload sends the idle octet 0xFF.

The rate mode is a static input that changes only while reset is asserted. In full mode all 24 T1 slots are carried. In D-channel mode T1 slot 24 is treated as meaningless and dropped, so E1 slot 24 goes idle as well.

A frame store with two banks sits between the two rates. The T1 side fills one bank while the E1 side reads the bank that was completed most recently. The bank is chosen at each E1 frame start, so every E1 frame carries octets from a single T1 frame.

Both line rates reach the block as one-cycle enables on a single system clock. The E1 strobe must come at least as often as the T1 strobe, and never on two clock cycles in a row.

Top module: `t1e1_slot_mapper`

## Requirements
- R1: After reset, e1_data is 1 and e1_frame_start is 0. Every E1 slot carries 0xFF until a complete T1 frame has been received.
- R2: A T1 frame has 193 bit positions. Position 0 is the framing bit, marked by t1_frame_pulse on its t1_bit_en cycle. Positions 1 to 192 hold slots 1 to 24 of 8 bits each, MSB first. The framing bit value never appears in the output.
- R3: With isdn_mode=0, the octet of T1 slot n (n = 1..24) is sent in E1 slot n, MSB first.
- R4: With isdn_mode=1, T1 slots 1..23 are sent in E1 slots 1..23. E1 slot 24 carries 0xFF, and the octet of T1 slot 24 is never written to the store.
- R5: E1 slot 0 and E1 slots 25 to 31 always carry 0xFF.
- R6: An E1 frame is 256 bit strobes long. e1_frame_start is 1 for exactly the first bit of slot 0. e1_data and e1_frame_start change only on the clock edge that samples e1_bit_en.
- R7: An E1 frame carries only the T1 frame whose last payload bit was sampled most recently, and at least two clock cycles before the first strobe of that E1 frame. A frame cut short by a new frame pulse is never carried.
- R8: Without a new frame pulse, T1 framing keeps running with a period of 193 strobes.
- R9: T1 input before the first frame pulse after reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| isdn_mode | input | 1 | 1: D-channel mode, 23 slots carried; 0: full mode, 24 slots carried |
| t1_bit_en | input | 1 | One-cycle strobe per T1 line bit |
| t1_frame_pulse | input | 1 | Marks the framing bit, qualified by t1_bit_en |
| t1_data | input | 1 | T1 serial data, sampled on t1_bit_en |
| e1_bit_en | input | 1 | One-cycle strobe per E1 line bit |
| e1_data | output | 1 | E1 serial data, registered |
| e1_frame_start | output | 1 | High during the first bit of E1 slot 0 |

## Verification
The bench builds the block with its default sizes: 24 T1 slots, 32 E1 slots and 8-bit octets. It strobes T1 every 4 clocks and E1 every 3 clocks, so the E1 frame comes out four clocks shorter than the T1 frame. Because of that drift, the bank swap lands at a different point of the E1 frame each time. Some T1 frames are also sent twice, which brings the choice of the most recent frame and bank reuse within reach. The sequence includes unframed input before the first pulse, frames held by the flywheel alone, and one frame cut short by an early pulse. It runs once in each mode.

// File: rtl/t1e1_pkg.sv
package t1e1_pkg;

  // Number of T1 slots that carry payload in the selected mode.
  function automatic int unsigned live_slots(input logic dch_mode, input int unsigned n_slots);
    return dch_mode ? (n_slots - 1) : n_slots;
  endfunction

endpackage

// File: rtl/t1e1_t1_capture.sv
module t1e1_t1_capture
  import t1e1_pkg::*;
#(
  parameter int N_SLOTS = 24,
  parameter int OCT_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         isdn,
  input  logic                         t1_en,
  input  logic                         t1_fp,
  input  logic                         t1_bit,
  output logic                         wr_en,
  output logic [$clog2(N_SLOTS)-1:0]   wr_addr,
  output logic [OCT_W-1:0]             wr_data,
  output logic                         frame_done
);
  localparam int FRAME_BITS = N_SLOTS * OCT_W + 1;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int ADDR_W     = $clog2(N_SLOTS);
  localparam int OCT_LG     = $clog2(OCT_W);

  logic [POS_W-1:0]  pos_q, pos_n, idx;
  logic              synced_q, accept, payload, octet_end, skip;
  logic [OCT_W-1:0]  sr_q, sr_n;
  logic [ADDR_W-1:0] slot;

  always_comb begin
    if (t1_fp || (pos_q == POS_W'(FRAME_BITS - 1))) pos_n = '0;
    else                                            pos_n = pos_q + 1'b1;
    idx       = pos_n - 1'b1;
    slot      = ADDR_W'(idx >> OCT_LG);
    payload   = (pos_n != '0);
    octet_end = payload && (idx[OCT_LG-1:0] == OCT_LG'(OCT_W - 1));
    sr_n      = {sr_q[OCT_W-2:0], t1_bit};
    accept    = t1_en && (t1_fp || synced_q);
    skip      = (32'(slot) >= live_slots(isdn, N_SLOTS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      synced_q   <= 1'b0;
      sr_q       <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      if (accept) begin
        pos_q    <= pos_n;
        synced_q <= 1'b1;
        if (payload) sr_q <= sr_n;
        if (octet_end) begin
          wr_en      <= !skip;
          wr_addr    <= slot;
          wr_data    <= sr_n;
          frame_done <= (slot == ADDR_W'(N_SLOTS - 1));
        end
      end
    end
  end

endmodule

// File: rtl/t1e1_frame_store.sv
module t1e1_frame_store #(
  parameter int N_SLOTS = 24,
  parameter int OCT_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(N_SLOTS)-1:0]  wr_addr,
  input  logic [OCT_W-1:0]            wr_data,
  input  logic                        frame_done,
  input  logic                        rd_latch,
  input  logic [$clog2(N_SLOTS)-1:0]  rd_addr,
  output logic [OCT_W-1:0]            rd_data,
  output logic                        rd_valid
);
  localparam int ADDR_W = $clog2(N_SLOTS);
  localparam int DEPTH  = 2 * (1 << ADDR_W);

  logic [OCT_W-1:0] mem [DEPTH];
  logic wbank_q, latest_q, have_q, rbank_q;

  // Plain write port and registered read port: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[{wbank_q, wr_addr}] <= wr_data;
    rd_data <= mem[{rbank_q, rd_addr}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank_q  <= 1'b0;
      latest_q <= 1'b0;
      have_q   <= 1'b0;
      rbank_q  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (frame_done) begin
        latest_q <= wbank_q;
        wbank_q  <= ~wbank_q;
        have_q   <= 1'b1;
      end
      if (rd_latch) begin
        rbank_q  <= latest_q;
        rd_valid <= have_q;
      end
    end
  end

endmodule

// File: rtl/t1e1_e1_serializer.sv
module t1e1_e1_serializer
  import t1e1_pkg::*;
#(
  parameter int N_E1  = 32,
  parameter int N_MAP = 24,
  parameter int OCT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      isdn,
  input  logic                      e1_en,
  output logic                      frame_start,
  output logic [$clog2(N_MAP)-1:0]  rd_addr,
  input  logic [OCT_W-1:0]          rd_data,
  input  logic                      rd_valid,
  output logic                      e1_bit,
  output logic                      e1_sof
);
  localparam int FRAME_BITS = N_E1 * OCT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SLOT_W     = $clog2(N_E1);
  localparam int ADDR_W     = $clog2(N_MAP);
  localparam int OCT_LG     = $clog2(OCT_W);

  logic [POS_W-1:0]  pos_q, pos_n;
  logic [SLOT_W-1:0] cur_slot, nxt_slot, last_map;
  logic [OCT_W-1:0]  sr_q, fill;
  logic              octet_start, mapped;

  always_comb begin
    pos_n       = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
    cur_slot    = SLOT_W'(pos_q >> OCT_LG);
    nxt_slot    = (cur_slot == SLOT_W'(N_E1 - 1)) ? '0 : cur_slot + 1'b1;
    octet_start = (pos_n[OCT_LG-1:0] == '0);
    last_map    = SLOT_W'(live_slots(isdn, N_MAP));
    mapped      = rd_valid && (nxt_slot != '0) && (nxt_slot <= last_map);
    fill        = mapped ? rd_data : {OCT_W{1'b1}};
    // Prefetch address: octet needed at the next slot boundary.
    rd_addr     = ADDR_W'(nxt_slot - 1'b1);
    frame_start = e1_en && (pos_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= POS_W'(FRAME_BITS - 1);
      sr_q   <= '1;
      e1_sof <= 1'b0;
    end else if (e1_en) begin
      pos_q  <= pos_n;
      e1_sof <= (pos_n == '0);
      sr_q   <= octet_start ? fill : {sr_q[OCT_W-2:0], 1'b1};
    end
  end

  assign e1_bit = sr_q[OCT_W-1];

endmodule

// File: rtl/t1e1_slot_mapper.sv
module t1e1_slot_mapper #(
  parameter int T1_SLOTS = 24,
  parameter int E1_SLOTS = 32,
  parameter int OCTET_W  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic isdn_mode,
  input  logic t1_bit_en,
  input  logic t1_frame_pulse,
  input  logic t1_data,
  input  logic e1_bit_en,
  output logic e1_data,
  output logic e1_frame_start
);
  localparam int ADDR_W = $clog2(T1_SLOTS);

  logic               st_wr_en, st_frame_done, rd_latch, rd_valid;
  logic [ADDR_W-1:0]  st_wr_addr, rd_addr;
  logic [OCTET_W-1:0] st_wr_data, rd_data;

  t1e1_t1_capture #(.N_SLOTS(T1_SLOTS), .OCT_W(OCTET_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .isdn       (isdn_mode),
    .t1_en      (t1_bit_en),
    .t1_fp      (t1_frame_pulse),
    .t1_bit     (t1_data),
    .wr_en      (st_wr_en),
    .wr_addr    (st_wr_addr),
    .wr_data    (st_wr_data),
    .frame_done (st_frame_done)
  );

  t1e1_frame_store #(.N_SLOTS(T1_SLOTS), .OCT_W(OCTET_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (st_wr_en),
    .wr_addr    (st_wr_addr),
    .wr_data    (st_wr_data),
    .frame_done (st_frame_done),
    .rd_latch   (rd_latch),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  t1e1_e1_serializer #(.N_E1(E1_SLOTS), .N_MAP(T1_SLOTS), .OCT_W(OCTET_W)) u_ser (
    .clk         (clk),
    .rst         (rst),
    .isdn        (isdn_mode),
    .e1_en       (e1_bit_en),
    .frame_start (rd_latch),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .e1_bit      (e1_data),
    .e1_sof      (e1_frame_start)
  );

endmodule

// File: rtl/t1e1_mapper_chk.sv
module t1e1_mapper_chk #(
  parameter int N_SLOTS = 24
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        isdn_mode,
  input logic                        t1_bit_en,
  input logic                        e1_bit_en,
  input logic                        e1_data,
  input logic                        e1_frame_start,
  input logic                        st_wr_en,
  input logic [$clog2(N_SLOTS)-1:0]  st_wr_addr,
  input logic                        st_frame_done
);
  // R6
  e1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !e1_bit_en |=> ($stable(e1_data) && $stable(e1_frame_start)));

  // R5
  slot0_idle_chk: assert property (@(posedge clk) disable iff (rst)
    e1_frame_start |-> e1_data);

  // R4
  isdn_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (isdn_mode && st_wr_en) |-> (st_wr_addr != ($clog2(N_SLOTS))'(N_SLOTS - 1)));

  // R4
  isdn_close_chk: assert property (@(posedge clk) disable iff (rst)
    (isdn_mode && st_frame_done) |-> !st_wr_en);

  // R3
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!isdn_mode && st_frame_done) |-> (st_wr_en && (st_wr_addr == ($clog2(N_SLOTS))'(N_SLOTS - 1))));

  // R2
  write_pace_chk: assert property (@(posedge clk) disable iff (rst)
    st_wr_en |-> $past(t1_bit_en));

endmodule

bind t1e1_slot_mapper t1e1_mapper_chk #(.N_SLOTS(T1_SLOTS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .isdn_mode      (isdn_mode),
  .t1_bit_en      (t1_bit_en),
  .e1_bit_en      (e1_bit_en),
  .e1_data        (e1_data),
  .e1_frame_start (e1_frame_start),
  .st_wr_en       (st_wr_en),
  .st_wr_addr     (st_wr_addr),
  .st_frame_done  (st_frame_done)
);

// File: tb/t1e1_slot_mapper_test.sv
module t1e1_slot_mapper_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic isdn_mode = 1'b0;
  logic t1_bit_en = 1'b0, t1_frame_pulse = 1'b0, t1_data = 1'b0, e1_bit_en = 1'b0;
  logic e1_data, e1_frame_start;

  t1e1_slot_mapper #(.T1_SLOTS(24), .E1_SLOTS(32), .OCTET_W(8)) uut (
    .clk(clk), .rst(rst), .isdn_mode(isdn_mode),
    .t1_bit_en(t1_bit_en), .t1_frame_pulse(t1_frame_pulse), .t1_data(t1_data),
    .e1_bit_en(e1_bit_en), .e1_data(e1_data), .e1_frame_start(e1_frame_start)
  );

  always #10 clk = ~clk;   // 50 MHz

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit t1_done = 1'b0;

  // Scoreboard: completed T1 frames with the cycle they count from.
  longint stamp_q[$];
  int     id_q[$];
  string  tag_q[$];

  logic [7:0] byt [32];

  function automatic logic [7:0] pat(input int k, input int j);
    return 8'((k * 37 + j * 11 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one T1 frame (or its first nbits), one strobe every 4 clocks.
  task automatic send_frame(input int k, input bit fp, input int nbits, input bit push, input string tag);
    for (int b = 0; b < nbits; b++) begin
      logic [7:0] v;
      @(negedge clk);
      t1_bit_en = 1'b1;
      t1_frame_pulse = fp && (b == 0);
      if (b == 0) t1_data = k[0];
      else begin
        v = pat(k, (b - 1) / 8);
        t1_data = v[7 - ((b - 1) % 8)];
      end
      if (b == 192 && push) begin
        stamp_q.push_back(cyc + 1);
        id_q.push_back(k);
        tag_q.push_back(tag);
      end
      @(negedge clk);
      t1_bit_en = 1'b0;
      t1_frame_pulse = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t1_seq(input string mtag);
    send_frame(100, 1'b0, 193, 1'b0, "");          // R9: no pulse yet, ignored
    send_frame(101, 1'b0, 150, 1'b0, "");
    send_frame(1, 1'b1, 193, 1'b1, {"R2 ", mtag});
    send_frame(2, 1'b0, 193, 1'b1, {"R8 ", mtag}); // flywheel framing
    send_frame(3, 1'b0, 193, 1'b1, {"R8 ", mtag});
    send_frame(4, 1'b1, 100, 1'b0, "");            // R7: cut short, never carried
    send_frame(5, 1'b1, 193, 1'b1, {"R7 ", mtag});
    send_frame(6, 1'b1, 193, 1'b1, {"R2 ", mtag});
    send_frame(7, 1'b0, 193, 1'b1, {"R8 ", mtag});
    t1_done = 1'b1;
  endtask

  // E1 strobe every 3 clocks; monitor collects each frame and compares it.
  task automatic e1_mon();
    int    bitcnt = -1;
    int    extra = 0;
    bit    cv = 1'b0;
    int    cid = 0;
    string ctag = "";
    logic  d, s;
    longint c;
    while (1) begin
      @(negedge clk);
      e1_bit_en = 1'b1;
      @(negedge clk);
      e1_bit_en = 1'b0;
      d = e1_data;
      s = e1_frame_start;
      c = cyc;
      if (s) begin
        if (bitcnt >= 0) begin
          check("R6", bitcnt, 256, "bits per E1 frame");
          for (int s2 = 0; s2 < 32; s2++) begin
            logic [7:0] ex;
            string tg;
            int lim;
            lim = isdn_mode ? 23 : 24;
            if (s2 == 0 || s2 > 24) begin ex = 8'hFF; tg = "R5"; end
            else if (s2 > lim)      begin ex = 8'hFF; tg = "R4"; end
            else if (!cv)           begin ex = 8'hFF; tg = "R1 R9"; end
            else                    begin ex = pat(cid, s2 - 1); tg = ctag; end
            check(tg, byt[s2], ex, $sformatf("E1 slot %0d", s2));
          end
        end
        if (t1_done) extra++;
        if (extra > 2) break;
        // R7: latest T1 frame completed before this E1 frame's first strobe
        while (stamp_q.size() > 0 && stamp_q[0] < c - 1) begin
          cv = 1'b1;
          cid = id_q.pop_front();
          ctag = tag_q.pop_front();
          void'(stamp_q.pop_front());
        end
        bitcnt = 0;
      end
      if (bitcnt >= 0 && bitcnt < 256) byt[bitcnt / 8][7 - (bitcnt % 8)] = d;
      if (bitcnt >= 0) bitcnt++;
      @(negedge clk);
    end
  endtask

  task automatic run_phase(input bit isdn);
    rst = 1'b1;
    isdn_mode = isdn;
    stamp_q.delete();
    id_q.delete();
    tag_q.delete();
    t1_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", e1_data, 1, "e1_data after reset");
    check("R1", e1_frame_start, 0, "e1_frame_start after reset");
    fork
      t1_seq(isdn ? "R4" : "R3");
      e1_mon();
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run_phase(1'b0);
    run_phase(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule